// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves the control-flow instructions of a 64-bit register machine whose program counter counts 64-bit instruction slots. Each cycle it can accept one instruction: the opcode byte, the 4-bit source-register field, the destination and source register values, the 32-bit immediate, the signed 16-bit offset and the current program counter. One cycle later it reports whether the branch is taken, the next program counter, and flags for calls, returns and undefined jump encodings.

Two jump classes exist. One compares full 64-bit operands. The other compares only the low 32-bit halves. Opcode bit 3 picks the right-hand operand: either the sign-extended immediate or the source register. The code field, in opcode bits 7..4, selects equality, inequality, bit-test, or an ordering compare in signed or unsigned form. Helper-call dispatch and return-stack handling are left to the surrounding core. The unit only classifies those instructions.

Control is a two-state machine. `ST_IDLE` means no result is presented. `ST_RESULT` means a result is presented for exactly one cycle. The transition `IDLE->RESULT` fires on `in_valid`. `RESULT->RESULT` fires on back-to-back `in_valid`. `RESULT->IDLE` fires when `in_valid` is low.

Top module: `bcu_top`

## Requirements
- R1: After reset, `res_valid` and `taken` are 0.
- R2: A result appears on the outputs, with `res_valid` high, in the cycle after `in_valid` is sampled. `res_valid` is low in any cycle that follows a cycle with `in_valid` low.
- R3: Opcode class bits [2:0] = 5 compare all 64 operand bits. Class 6 compares only bits [31:0] of both operands.
- R4: Opcode bit 3 = 0 selects the 32-bit immediate, sign-extended to 64 bits, as the right operand. Bit 3 = 1 selects the source register value.
- R5: Code 0x2 (greater), 0x3 (greater-or-equal), 0xA (less) and 0xB (less-or-equal) are unsigned compares of destination against right operand.
- R6: Code 0x6 (greater), 0x7 (greater-or-equal), 0xC (less) and 0xD (less-or-equal) are two's-complement signed compares at the class width. Opcode 0x7E is a signed greater-or-equal of the low 32 bits against the source register.
- R7: Code 0x1 is taken on equal operands, code 0x5 on unequal operands, and code 0x4 when the bitwise AND of the operands is non-zero.
- R8: A taken branch gives `next_pc` = pc + sign-extended offset + 1. Any result that is not taken gives `next_pc` = pc + 1. Both wrap modulo 2^PC_W.
- R9: Code 0x0 in class 5 is always taken.
- R10: Code 0x9 in class 5 sets `is_exit` and is not taken.
- R11: Code 0x8 sets `is_call`, and `call_kind` equals the source field. Source field 0 (helper by address) and 2 (helper by type id) are not taken. Source field 1 (local call) is taken to the offset target. `call_kind` is 0 whenever `is_call` is 0.
- R12: Code 0xE, code 0xF, code 0x0 or code 0x9 in class 6, and code 0x8 with a source field above 2 each raise `illegal_op`. Such a result is not taken and has `is_call` and `is_exit` low.
- R13: Opcodes whose class is neither 5 nor 6 produce no taken, call, exit or illegal flag, and give `next_pc` = pc + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| opcode | input | 8 | Opcode byte: code[7:4], operand select[3], class[2:0] |
| src_field | input | 4 | Source register field of the instruction |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate |
| offset | input | 16 | Signed slot offset |
| pc | input | PC_W | Current program counter, in slots |
| res_valid | output | 1 | Result presented this cycle |
| taken | output | 1 | Branch or local call taken |
| next_pc | output | PC_W | Following program counter |
| is_call | output | 1 | Call instruction |
| call_kind | output | 2 | Call type: 0 helper by address, 1 local, 2 helper by type id |
| is_exit | output | 1 | Return instruction |
| illegal_op | output | 1 | Undefined jump-class encoding |

## Verification
Every result is due exactly one clock after its `in_valid` cycle, because a single register stage lies between the inputs and the outputs. The driver applies stimulus on the falling edge and pushes the model's expectation into a queue. The monitor samples just after the next falling edge, after the registering rising edge has passed. When it sees `res_valid` it pops the queue, and it flags any `res_valid` that arrives with nothing queued. Idle gaps are inserted so that the monitor also sees `res_valid` go low.

// File: rtl/bcu_pkg.sv
`timescale 1ns/1ps
package bcu_pkg;

    localparam logic [2:0] CLS_J64 = 3'd5;
    localparam logic [2:0] CLS_J32 = 3'd6;

    typedef enum logic [3:0] {
        CD_JA   = 4'h0, CD_JEQ  = 4'h1, CD_JGT  = 4'h2, CD_JGE  = 4'h3,
        CD_JSET = 4'h4, CD_JNE  = 4'h5, CD_JSGT = 4'h6, CD_JSGE = 4'h7,
        CD_CALL = 4'h8, CD_EXIT = 4'h9, CD_JLT  = 4'hA, CD_JLE  = 4'hB,
        CD_JSLT = 4'hC, CD_JSLE = 4'hD
    } br_code_e;

    typedef enum logic [2:0] {
        K_NONE, K_COND, K_ALWAYS, K_CALL_LOCAL, K_CALL_HELPER, K_EXIT, K_BAD
    } br_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } bcu_state_e;

endpackage

// File: rtl/bcu_decode.sv
`timescale 1ns/1ps
module bcu_decode
    import bcu_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [3:0] src_field,
    output br_kind_e   kind,
    output logic       half,
    output logic       use_reg,
    output logic [3:0] code
);
    logic [2:0] cls;
    logic       is_jmp;

    assign cls     = opcode[2:0];
    assign code    = opcode[7:4];
    assign use_reg = opcode[3];
    assign half    = (cls == CLS_J32);
    assign is_jmp  = (cls == CLS_J64) || (cls == CLS_J32);

    always_comb begin
        kind = K_NONE;
        if (is_jmp) begin
            case (code)
                CD_JA:   kind = half ? K_BAD : K_ALWAYS;
                CD_EXIT: kind = half ? K_BAD : K_EXIT;
                CD_CALL: begin
                    case (src_field)
                        4'd0, 4'd2: kind = K_CALL_HELPER;
                        4'd1:       kind = K_CALL_LOCAL;
                        default:    kind = K_BAD;
                    endcase
                end
                CD_JEQ, CD_JGT, CD_JGE, CD_JSET, CD_JNE, CD_JSGT, CD_JSGE,
                CD_JLT, CD_JLE, CD_JSLT, CD_JSLE: kind = K_COND;
                default: kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/bcu_compare.sv
`timescale 1ns/1ps
module bcu_compare
    import bcu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              half,
    input  logic [3:0]        code,
    output logic              cond
);
    localparam int NW = 2;

    logic [NW-1:0] eq_w, ult_w, slt_w, any_w;
    logic          eq, ult, slt, any;

    // index 0: full width, index 1: low half
    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int W = (g == 0) ? DATA_W : DATA_W / 2;
        logic [W-1:0] a, b;
        assign a        = lhs[W-1:0];
        assign b        = rhs[W-1:0];
        assign eq_w[g]  = (a == b);
        assign ult_w[g] = (a < b);
        assign slt_w[g] = ($signed(a) < $signed(b));
        assign any_w[g] = |(a & b);
    end

    assign eq  = eq_w[half];
    assign ult = ult_w[half];
    assign slt = slt_w[half];
    assign any = any_w[half];

    always_comb begin
        case (code)
            CD_JEQ:  cond = eq;
            CD_JNE:  cond = !eq;
            CD_JSET: cond = any;
            CD_JGT:  cond = !ult && !eq;
            CD_JGE:  cond = !ult;
            CD_JLT:  cond = ult;
            CD_JLE:  cond = ult || eq;
            CD_JSGT: cond = !slt && !eq;
            CD_JSGE: cond = !slt;
            CD_JSLT: cond = slt;
            CD_JSLE: cond = slt || eq;
            default: cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcu_target.sv
`timescale 1ns/1ps
module bcu_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic             take,
    output logic [PC_W-1:0]  npc
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext, seq_pc, jmp_pc;

    assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign seq_pc  = pc + PC_W'(1);
    assign jmp_pc  = seq_pc + off_ext;
    assign npc     = take ? jmp_pc : seq_pc;
endmodule

// File: rtl/bcu_top.sv
`timescale 1ns/1ps
module bcu_top
    import bcu_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [3:0]        src_field,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [OFF_W-1:0]  offset,
    input  logic [PC_W-1:0]   pc,
    output logic              res_valid,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc,
    output logic              is_call,
    output logic [1:0]        call_kind,
    output logic              is_exit,
    output logic              illegal_op
);
    localparam int IEXT_W = DATA_W - IMM_W;

    bcu_state_e      state_q, state_d;
    br_kind_e        kind;
    logic            half, use_reg, cond, take_d;
    logic [3:0]      code;
    logic [DATA_W-1:0] rhs;
    logic [PC_W-1:0] npc_d;

    bcu_decode u_dec (
        .opcode    (opcode),
        .src_field (src_field),
        .kind      (kind),
        .half      (half),
        .use_reg   (use_reg),
        .code      (code)
    );

    assign rhs = use_reg ? src_val : {{IEXT_W{imm[IMM_W-1]}}, imm};

    bcu_compare #(.DATA_W(DATA_W)) u_cmp (
        .lhs  (dst_val),
        .rhs  (rhs),
        .half (half),
        .code (code),
        .cond (cond)
    );

    assign take_d = (kind == K_ALWAYS) || (kind == K_CALL_LOCAL) ||
                    ((kind == K_COND) && cond);

    bcu_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc     (pc),
        .offset (offset),
        .take   (take_d),
        .npc    (npc_d)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken      <= 1'b0;
            next_pc    <= '0;
            is_call    <= 1'b0;
            call_kind  <= 2'd0;
            is_exit    <= 1'b0;
            illegal_op <= 1'b0;
        end else if (in_valid) begin
            taken      <= take_d;
            next_pc    <= npc_d;
            is_call    <= (kind == K_CALL_LOCAL) || (kind == K_CALL_HELPER);
            call_kind  <= ((kind == K_CALL_LOCAL) || (kind == K_CALL_HELPER))
                          ? src_field[1:0] : 2'd0;
            is_exit    <= (kind == K_EXIT);
            illegal_op <= (kind == K_BAD);
        end
    end

    assign res_valid = (state_q == ST_RESULT);
endmodule

// File: rtl/bcu_chk.sv
`timescale 1ns/1ps
module bcu_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [PC_W-1:0] pc,
    input logic            res_valid,
    input logic            taken,
    input logic [PC_W-1:0] next_pc,
    input logic            is_call,
    input logic [1:0]      call_kind,
    input logic            is_exit,
    input logic            illegal_op
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    // R8
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid ##1 (res_valid && !taken)) |-> next_pc == PC_W'($past(pc) + PC_W'(1)));
    // R10
    exit_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && is_exit) |-> !taken);
    // R12
    illegal_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && illegal_op) |-> (!taken && !is_call && !is_exit));
    // R11
    call_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !is_call) |-> call_kind == 2'd0);
    // R11
    helper_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && is_call && call_kind != 2'd1) |-> !taken);
endmodule

bind bcu_top bcu_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .pc         (pc),
    .res_valid  (res_valid),
    .taken      (taken),
    .next_pc    (next_pc),
    .is_call    (is_call),
    .call_kind  (call_kind),
    .is_exit    (is_exit),
    .illegal_op (illegal_op)
);

// File: tb/sim_bcu_top.sv
`timescale 1ns/1ps
module sim_bcu_top;
    localparam int PC_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        opcode = '0;
    logic [3:0]        src_field = '0;
    logic [63:0]       dst_val = '0;
    logic [63:0]       src_val = '0;
    logic [31:0]       imm = '0;
    logic [15:0]       offset = '0;
    logic [PC_W-1:0]   pc = '0;
    logic              res_valid, taken, is_call, is_exit, illegal_op;
    logic [PC_W-1:0]   next_pc;
    logic [1:0]        call_kind;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic            tk;
        logic [PC_W-1:0] npc;
        logic            cl;
        logic [1:0]      ck;
        logic            ex;
        logic            il;
        string           tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    bcu_top #(.PC_W(PC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .src_field(src_field), .dst_val(dst_val), .src_val(src_val),
        .imm(imm), .offset(offset), .pc(pc), .res_valid(res_valid),
        .taken(taken), .next_pc(next_pc), .is_call(is_call),
        .call_kind(call_kind), .is_exit(is_exit), .illegal_op(illegal_op)
    );

    // Reference from the requirements: 32-bit compares done on sign-extended
    // halves, which keeps signed and unsigned order and equality.
    function automatic exp_t model(input logic [7:0] op, input logic [3:0] sf,
                                   input logic [63:0] d, input logic [63:0] s,
                                   input logic [31:0] im, input logic [15:0] off,
                                   input logic [PC_W-1:0] p, input string tag);
        exp_t e;
        logic [63:0] r, a, b;
        logic go;
        e.tk = 0; e.cl = 0; e.ck = 0; e.ex = 0; e.il = 0; e.tag = tag;
        go = 0;
        if (op[2:0] == 3'd5 || op[2:0] == 3'd6) begin
            r = op[3] ? s : {{32{im[31]}}, im};
            if (op[2:0] == 3'd6) begin
                a = {{32{d[31]}}, d[31:0]};
                b = {{32{r[31]}}, r[31:0]};
            end else begin
                a = d; b = r;
            end
            case (op[7:4])
                4'h0: if (op[2:0] == 3'd5) go = 1; else e.il = 1;
                4'h9: if (op[2:0] == 3'd5) e.ex = 1; else e.il = 1;
                4'h8: if (sf > 4'd2) e.il = 1;
                      else begin e.cl = 1; e.ck = sf[1:0]; go = (sf == 4'd1); end
                4'h1: go = (a == b);
                4'h5: go = (a != b);
                4'h4: go = ((a & b) != 0);
                4'h2: go = (a > b);
                4'h3: go = (a >= b);
                4'hA: go = (a < b);
                4'hB: go = (a <= b);
                4'h6: go = ($signed(a) > $signed(b));
                4'h7: go = ($signed(a) >= $signed(b));
                4'hC: go = ($signed(a) < $signed(b));
                4'hD: go = ($signed(a) <= $signed(b));
                default: e.il = 1;
            endcase
        end
        e.tk  = go;
        e.npc = go ? p + {{(PC_W-16){off[15]}}, off} + PC_W'(1) : p + PC_W'(1);
        return e;
    endfunction

    task automatic issue(input logic [7:0] op, input logic [3:0] sf,
                         input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] im, input logic [15:0] off,
                         input logic [PC_W-1:0] p, input string tag);
        @(negedge clk);
        opcode = op; src_field = sf; dst_val = d; src_val = s;
        imm = im; offset = off; pc = p; in_valid = 1'b1;
        q.push_back(model(op, sf, d, s, im, off, p, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && res_valid) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R2: res_valid=1 expected 0 (no pending issue)");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (taken !== e.tk || next_pc !== e.npc || is_call !== e.cl ||
                    call_kind !== e.ck || is_exit !== e.ex || illegal_op !== e.il) begin
                    fails++;
                    $display("FAIL %s: got tk=%0b npc=%0h call=%0b ck=%0d ex=%0b il=%0b expected tk=%0b npc=%0h call=%0b ck=%0d ex=%0b il=%0b",
                             e.tag, taken, next_pc, is_call, call_kind, is_exit, illegal_op,
                             e.tk, e.npc, e.cl, e.ck, e.ex, e.il);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, got no finish expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (res_valid !== 1'b0 || taken !== 1'b0) begin
            fails++;
            $display("FAIL R1: res_valid=%0b taken=%0b expected 0 0", res_valid, taken);
        end
        @(negedge clk); rst_n = 1'b1;

        // R9 / R8 unconditional jump, positive, negative and wrapping offsets
        issue(8'h05, 0, 0, 0, 0, 16'd5, 32'd10, "R9");
        issue(8'h05, 0, 0, 0, 0, 16'hFFFD, 32'd10, "R8");
        issue(8'h05, 0, 0, 0, 0, 16'hFFFF, 32'd0, "R8");
        issue(8'h05, 0, 0, 0, 0, 16'd0, 32'hFFFF_FFFF, "R8");
        idle(1);
        // R2 gap: res_valid must be low now
        @(negedge clk); #2;
        checks++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2: res_valid=%0b expected 0 after idle", res_valid);
        end

        // R7 equality, inequality, bit test
        issue(8'h15, 0, 64'd21, 0, 32'd21, 16'd4, 32'd100, "R7");
        issue(8'h15, 0, 64'd22, 0, 32'd21, 16'd4, 32'd100, "R7");
        issue(8'h5D, 0, 64'd1, 64'd2, 0, 16'd7, 32'd200, "R7");
        issue(8'h45, 0, 64'h0F0, 0, 32'h010, 16'd3, 32'd50, "R7");
        issue(8'h45, 0, 64'h0F0, 0, 32'h00F, 16'd3, 32'd50, "R7");

        // R5 unsigned compares with -1 on the right
        issue(8'h2D, 0, 64'd1, '1, 0, 16'd9, 32'd0, "R5");
        issue(8'hAD, 0, 64'd1, '1, 0, 16'd9, 32'd0, "R5");
        issue(8'h3D, 0, 64'd7, 64'd7, 0, 16'd2, 32'd0, "R5");
        issue(8'hBD, 0, 64'd8, 64'd7, 0, 16'd2, 32'd0, "R5");

        // R6 signed compares
        issue(8'h6D, 0, 64'd1, '1, 0, 16'd9, 32'd0, "R6");
        issue(8'hCD, 0, '1, 64'd1, 0, 16'd9, 32'd0, "R6");
        issue(8'hDD, 0, 64'd5, 64'd5, 0, 16'd1, 32'd0, "R6");
        issue(8'h7E, 0, 64'h1_8000_0000, 64'd1, 0, 16'd6, 32'd40, "R6");
        issue(8'h7D, 0, 64'h1_8000_0000, 64'd1, 0, 16'd6, 32'd40, "R3");

        // R3 32-bit class ignores the upper halves
        issue(8'h1E, 0, 64'h1_0000_0005, 64'd5, 0, 16'd2, 32'd8, "R3");
        issue(8'h1D, 0, 64'h1_0000_0005, 64'd5, 0, 16'd2, 32'd8, "R3");

        // R4 operand select and immediate sign extension
        issue(8'h15, 0, '1, 64'd0, 32'hFFFF_FFFF, 16'd3, 32'd12, "R4");
        issue(8'h1D, 0, '1, 64'd0, 32'hFFFF_FFFF, 16'd3, 32'd12, "R4");
        idle(2);

        // R10 return
        issue(8'h95, 0, 0, 0, 0, 16'd5, 32'd30, "R10");
        // R11 calls
        issue(8'h85, 4'd0, 0, 0, 32'd77, 16'd5, 32'd30, "R11");
        issue(8'h85, 4'd1, 0, 0, 0, 16'd20, 32'd30, "R11");
        issue(8'h85, 4'd2, 0, 0, 32'd99, 16'd5, 32'd30, "R11");
        issue(8'h86, 4'd1, 0, 0, 0, 16'hFFF0, 32'd30, "R11");
        // R12 undefined encodings
        issue(8'h85, 4'd3, 0, 0, 0, 16'd5, 32'd30, "R12");
        issue(8'hE5, 0, 0, 0, 0, 16'd5, 32'd30, "R12");
        issue(8'hF6, 0, 0, 0, 0, 16'd5, 32'd30, "R12");
        issue(8'h06, 0, 0, 0, 0, 16'd5, 32'd30, "R12");
        issue(8'h96, 0, 0, 0, 0, 16'd5, 32'd30, "R12");
        // R13 non-jump classes
        issue(8'h07, 0, 0, 0, 0, 16'd5, 32'd60, "R13");
        issue(8'h61, 0, 0, 0, 0, 16'd5, 32'd61, "R13");
        idle(4);

        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d results outstanding expected 0", q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule